// File: doc/BRIEF.md
# PWM Channel with Steady-State Boundary Handling

This block is one pulse-width-modulation channel. A 16-bit counter advances on each cycle where an external PWM clock-enable strobe is high. It counts from zero up to the active period minus one and then wraps. The output is at its active level while the counter is below the active pulse-width value, and at its inactive level otherwise. The inversion bit in the control register sets which pin level counts as active.

Software reaches four registers over a simple register bus: control/status, period, pulse width and counter. Writes to period and pulse width go into buffers. The channel copies the buffers into its active registers only at a counter wrap, so a running period is never shortened. While the channel is disabled, the active registers follow the buffers.

Two cases hold the output at a steady level with no glitch pulse. A pulse width of zero gives 0% duty. A pulse width at or above the period gives 100% duty. A period value of zero means 65536 ticks, so in that case the highest duty is 65535/65536. The counter keeps running in both steady cases. A period-complete flag is set at every wrap and can raise an interrupt request.

The register bus has no handshake. An access completes in the cycle where `bus_sel` is high, and the block never pushes back. Reads are combinational and have no side effects. Writes take effect at the next clock edge.

Top module: `pwm_chan`

## Requirements
- R1: After reset, the control register reads 0, both buffers and the counter read 0, `pwm_out` is 0 and `irq` is 0.
- R2: While enabled, the counter increments only on cycles with `pwm_tick` high. After the value P-1 it returns to 0, where P is the active period. A period value of 0 counts as P = 65536.
- R3: Period and width writes go to buffers, which read back at addresses 1 and 2. The active copies take the buffer values only at a counter wrap, or on any cycle while the channel is disabled. A period write during a running period does not change where that period ends.
- R4: `pwm_out` shows the counter state with one clock of latency. For counter value c it is the active level when c < W, where W is the active width, and the inactive level otherwise.
- R5: Width 0 holds `pwm_out` at the inactive level. The counter keeps counting.
- R6: Width >= P, with P nonzero, holds `pwm_out` at the active level. With period 0 and width 0xFFFF, exactly one inactive cycle occurs in every 65536 ticks.
- R7: Control bit 2 (invert) = 0 makes the active level 1. Control bit 2 = 1 makes the active level 0 and the inactive level 1.
- R8: Control bit 3 (flag) sets on every wrap. Writing 1 to bit 3 at address 0 clears it, and a wrap in the same cycle keeps it set. `irq` = flag AND control bit 1 (interrupt enable).
- R9: With control bit 0 (enable) = 0, the counter is held at 0 and `pwm_out` is at the inactive level from the cycle after enable is cleared.
- R10: Control bits 15..4 read as 0. Addresses 4 to 7 read as 0, and writes to them change nothing. The counter register at address 3 ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_tick | input | 1 | PWM clock-enable strobe |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address (0 ctrl, 1 period, 2 width, 3 counter) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (0 when not selected) |
| pwm_out | output | 1 | Modulated output pin |
| irq | output | 1 | Period-complete interrupt request |

## Verification
The bench drives several directed patterns:

- A short period with a mid-range width. Counting active cycles here separates a correct compare from an off-by-one compare.
- A width of zero, and a width past the period. Both must give steady levels under either inversion setting. Reading the counter shows it still advances.
- A period rewritten mid-period. The observed counter maximum tells immediate loading apart from loading at the wrap.
- A full 65536-tick period with width 0xFFFF. This must give exactly one inactive cycle.

After the directed patterns, a seeded random phase interleaves writes, reads and sparse ticks. It compares every cycle against a reference model built from the requirements.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_PER   = 3'd1,
    RA_WID   = 3'd2,
    RA_COUNT = 3'd3
  } reg_addr_e;

  localparam int BIT_EN   = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_INV  = 2;
  localparam int BIT_FLAG = 3;

  typedef struct packed {
    logic flag;
    logic inv;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     wdata_i,
  input  logic              wrap_i,
  input  logic [CW-1:0]     cnt_i,
  output logic [CW-1:0]     rdata_o,
  output ctrl_t             ctrl_o,
  output logic [CW-1:0]     per_buf_o,
  output logic [CW-1:0]     wid_buf_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t         ctrl_q;
  logic [CW-1:0] per_q, wid_q;
  logic          wr_ctrl, wr_per, wr_wid, flag_clr;

  assign wr_ctrl  = sel_i && wr_i && (addr_i == RA_CTRL);
  assign wr_per   = sel_i && wr_i && (addr_i == RA_PER);
  assign wr_wid   = sel_i && wr_i && (addr_i == RA_WID);
  assign flag_clr = wr_ctrl && wdata_i[BIT_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      wid_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en  <= wdata_i[BIT_EN];
        ctrl_q.ie  <= wdata_i[BIT_IE];
        ctrl_q.inv <= wdata_i[BIT_INV];
      end
      // a wrap in the same cycle keeps the flag set
      ctrl_q.flag <= wrap_i | (ctrl_q.flag & ~flag_clr);
      if (wr_per) per_q <= wdata_i;
      if (wr_wid) wid_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (addr_i)
        RA_CTRL:  rdata_o = {{(CW-CTRL_W){1'b0}}, ctrl_q};
        RA_PER:   rdata_o = per_q;
        RA_WID:   rdata_o = wid_q;
        RA_COUNT: rdata_o = cnt_i;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o    = ctrl_q;
  assign per_buf_o = per_q;
  assign wid_buf_o = wid_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [CW-1:0] per_buf_i,
  input  logic [CW-1:0] wid_buf_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] per_act_o,
  output logic [CW-1:0] wid_act_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, per_q, wid_q, last_val;
  logic          wrap;

  // period 0 wraps to all ones: a full 2^CW count
  assign last_val = per_q - CW'(1);
  assign wrap     = en_i && tick_i && (cnt_q == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      wid_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      per_q <= per_buf_i;
      wid_q <= wid_buf_i;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q <= '0;
        per_q <= per_buf_i;
        wid_q <= wid_buf_i;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign per_act_o = per_q;
  assign wid_act_o = wid_q;
  assign wrap_o    = wrap;
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          inv_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] wid_i,
  output logic          pwm_o
);
  logic active, out_q;

  // width 0 never matches; width >= period always matches
  assign active = en_i && (cnt_i < wid_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= active ^ inv_i;
  end

  assign pwm_o = out_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CW-1:0]     bus_wdata,
  output logic [CW-1:0]     bus_rdata,
  output logic              pwm_out,
  output logic              irq
);
  ctrl_t         ctrl;
  logic [CW-1:0] per_buf, wid_buf, cnt, per_act, wid_act;
  logic          wrap;
  logic          en_w, inv_w, flag_w;

  assign en_w   = ctrl.en;
  assign inv_w  = ctrl.inv;
  assign flag_w = ctrl.flag;

  pwm_regs #(.CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .wrap_i(wrap), .cnt_i(cnt), .rdata_o(bus_rdata), .ctrl_o(ctrl),
    .per_buf_o(per_buf), .wid_buf_o(wid_buf)
  );

  pwm_timebase #(.CW(CW)) tb_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .tick_i(pwm_tick),
    .per_buf_i(per_buf), .wid_buf_i(wid_buf),
    .cnt_o(cnt), .per_act_o(per_act), .wid_act_o(wid_act), .wrap_o(wrap)
  );

  pwm_outstage #(.CW(CW)) out_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .inv_i(inv_w),
    .cnt_i(cnt), .wid_i(wid_act), .pwm_o(pwm_out)
  );

  assign irq = ctrl.flag & ctrl.ie;
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          en,
  input logic          inv,
  input logic          flag,
  input logic          wrap,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per_act,
  input logic [CW-1:0] wid_act,
  input logic          pwm_out
);
  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  // R2
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_act != '0) |-> (cnt < per_act));

  // R3
  reload_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(per_act) && $stable(wid_act)));

  // R8
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);

  // R5
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wid_act == '0) |=> (pwm_out == $past(inv)));

  // R6
  full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_act != '0 && wid_act >= per_act) |=> (pwm_out == !$past(inv)));
endmodule

bind pwm_chan pwm_chan_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(pwm_tick), .en(en_w), .inv(inv_w),
  .flag(flag_w), .wrap(wrap), .cnt(cnt), .per_act(per_act),
  .wid_act(wid_act), .pwm_out(pwm_out)
);

// File: tb/pwm_chan_tb_top.sv
module pwm_chan_tb_top;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwm_tick = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          pwm_out, irq;

  int checks = 0, errors = 0;
  bit done = 1'b0, live = 1'b0;

  always #4 clk = ~clk;

  pwm_chan #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  // reference model written from the requirements
  logic [CW-1:0] m_cnt, m_per, m_wid, m_pbuf, m_wbuf;
  logic          m_en, m_ie, m_inv, m_flag, m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_per <= '0; m_wid <= '0; m_pbuf <= '0; m_wbuf <= '0;
      m_en <= 0; m_ie <= 0; m_inv <= 0; m_flag <= 0; m_out <= 0;
    end else begin
      logic w, clr;
      w   = m_en && pwm_tick && (m_cnt == m_per - 16'd1);
      clr = bus_sel && bus_wr && bus_addr == 3'd0 && bus_wdata[3];
      m_out <= (m_en && (m_cnt < m_wid)) ^ m_inv;
      if (!m_en) begin
        m_cnt <= '0; m_per <= m_pbuf; m_wid <= m_wbuf;
      end else if (pwm_tick) begin
        if (w) begin m_cnt <= '0; m_per <= m_pbuf; m_wid <= m_wbuf; end
        else m_cnt <= m_cnt + 16'd1;
      end
      m_flag <= w | (m_flag & ~clr);
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          3'd0: begin m_en <= bus_wdata[0]; m_ie <= bus_wdata[1]; m_inv <= bus_wdata[2]; end
          3'd1: m_pbuf <= bus_wdata;
          3'd2: m_wbuf <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [CW-1:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {12'b0, m_flag, m_inv, m_ie, m_en};
      3'd1: return m_pbuf;
      3'd2: return m_wbuf;
      3'd3: return m_cnt;
      default: return '0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [CW-1:0] got,
                       input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  // cycle-by-cycle output comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      check(pwm_out == m_out, "R4 pwm_out", CW'(pwm_out), CW'(m_out));
      check(irq == (m_flag & m_ie), "R8 irq", CW'(irq), CW'(m_flag & m_ie));
    end
  end

  task automatic idle(input logic t);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; pwm_tick = t;
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d, input logic t);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; pwm_tick = t;
  endtask

  task automatic rd_raw(input logic [2:0] a, input logic t, output logic [CW-1:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; pwm_tick = t;
    #1 v = bus_rdata;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic t, input logic [CW-1:0] exp,
                        input string req);
    logic [CW-1:0] v;
    rd_raw(a, t, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic rd_model(input logic [2:0] a, input logic t, input string req);
    logic [CW-1:0] v, e;
    rd_raw(a, t, v);
    e = m_read(a);
    check(v == e, req, v, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v, a0, mx;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(pwm_out == 0, "R1 pwm_out", CW'(pwm_out), 0);
    check(irq == 0, "R1 irq", CW'(irq), 0);
    rd_exp(3'd0, 0, 16'h0, "R1 ctrl");
    rd_exp(3'd1, 0, 16'h0, "R1 period buf");
    rd_exp(3'd3, 0, 16'h0, "R1 counter");
    live = 1;

    // R4 period 10, width 4
    wr(3'd1, 16'd10, 0); wr(3'd2, 16'd4, 0); wr(3'd0, 16'h1, 1);
    repeat (15) idle(1);
    n = 0;
    for (int i = 0; i < 30; i++) begin idle(1); if (pwm_out) n++; end
    check(n == 12, "R4 active cycles per 30", CW'(n), 16'd12);

    // R2 no tick, counter stable
    rd_raw(3'd3, 0, a0);
    repeat (5) idle(0);
    rd_exp(3'd3, 0, a0, "R2 counter held without tick");

    // R3 mid-period period write does not cut the period
    do rd_raw(3'd3, 1, v); while (v != 16'd2);
    wr(3'd1, 16'd6, 1);
    mx = 0;
    do begin rd_raw(3'd3, 1, v); if (v > mx) mx = v; end while (v != 0);
    check(mx == 16'd9, "R3 old period kept", mx, 16'd9);
    mx = 0;
    do begin rd_raw(3'd3, 1, v); if (v > mx) mx = v; end while (v != 0);
    check(mx == 16'd5, "R3 new period used", mx, 16'd5);
    rd_exp(3'd1, 1, 16'd6, "R3 period buffer readback");

    // R5 width 0
    wr(3'd2, 16'd0, 1);
    repeat (10) idle(1);
    n = 0;
    for (int i = 0; i < 30; i++) begin idle(1); if (pwm_out) n++; end
    check(n == 0, "R5 no active cycles", CW'(n), 0);
    rd_raw(3'd3, 1, a0);
    repeat (3) idle(1);
    rd_exp(3'd3, 1, (a0 + 16'd4) % 16'd6, "R5 counter runs");

    // R6 width above period, then R7 inverted
    wr(3'd2, 16'd20, 1);
    repeat (10) idle(1);
    n = 0;
    for (int i = 0; i < 30; i++) begin idle(1); if (pwm_out) n++; end
    check(n == 30, "R6 always active", CW'(n), 16'd30);
    wr(3'd0, 16'h5, 1);
    repeat (3) idle(1);
    n = 0;
    for (int i = 0; i < 30; i++) begin idle(1); if (pwm_out) n++; end
    check(n == 0, "R7 inverted active level is 0", CW'(n), 0);
    wr(3'd2, 16'd0, 1);
    repeat (10) idle(1);
    n = 0;
    for (int i = 0; i < 20; i++) begin idle(1); if (pwm_out) n++; end
    check(n == 20, "R7 inverted inactive level is 1", CW'(n), 16'd20);

    // R6 period 65536, width 0xFFFF
    wr(3'd0, 16'h1, 1); wr(3'd1, 16'd0, 1); wr(3'd2, 16'hFFFF, 1);
    repeat (20) idle(1);
    n = 0;
    for (int i = 0; i < 65536; i++) begin idle(1); if (!pwm_out) n++; end
    check(n == 1, "R6 one inactive cycle in 65536", CW'(n), 16'd1);

    // R8 flag and interrupt
    wr(3'd1, 16'd8, 1); wr(3'd2, 16'd3, 1); wr(3'd0, 16'h3, 1);
    n = 0;
    for (int i = 0; i < 70000 && !irq; i++) idle(1);
    check(irq == 1, "R8 irq after wrap", CW'(irq), 1);
    rd_exp(3'd0, 0, 16'hB, "R8 flag set");
    wr(3'd0, 16'hB, 0);
    rd_exp(3'd0, 0, 16'h3, "R8 flag cleared by write 1");
    check(irq == 0, "R8 irq low after clear", CW'(irq), 0);

    // R9 disable
    wr(3'd0, 16'h4, 1);
    idle(1);
    rd_exp(3'd3, 1, 16'h0, "R9 counter held at 0");
    check(pwm_out == 1, "R9 inactive level while disabled", CW'(pwm_out), 1);

    // R10 reserved bits and addresses
    wr(3'd5, 16'hFFFF, 1);
    rd_exp(3'd5, 1, 16'h0, "R10 reserved addr reads 0");
    rd_exp(3'd6, 1, 16'h0, "R10 reserved addr reads 0");
    rd_exp(3'd1, 1, 16'd8, "R10 period buf untouched");
    rd_exp(3'd2, 1, 16'd3, "R10 width buf untouched");
    wr(3'd0, 16'hFFF0, 1);
    rd_exp(3'd0, 1, 16'h0, "R10 upper ctrl bits read 0");
    wr(3'd3, 16'h55, 1);
    rd_exp(3'd3, 1, 16'h0, "R10 counter ignores writes");

    // random phase
    wr(3'd0, 16'h3, 1);
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic t;
      r = $urandom % 16;
      t = ($urandom % 3) != 0;
      case (r)
        0: wr(3'd1, CW'(1 + $urandom % 15), t);
        1: wr(3'd2, CW'($urandom % 18), t);
        2: wr(3'd0, CW'($urandom % 16) | 16'h1, t);
        3: wr(3'd0, 16'h0, t);
        4, 5: rd_model(3'(($urandom) % 8), t, "R2 R3 R10 random read");
        default: idle(t);
      endcase
    end
    idle(0);
    rd_model(3'd3, 0, "R2 final counter");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule